// File: doc/BRIEF.md
# Toggle-Handshake Message Transmitter

This block sends a fixed twelve-character text message over an 8-bit parallel link, one byte at a time. Each transfer is marked by a change in the level of the strobe output, not by a pulse. The receiver answers by changing the level of the acknowledge input. The message is stored in a constant table inside the block and is sent in index order, starting at index 0.

Before each byte the transmitter waits while the acknowledge level equals the strobe level. Once the two levels differ, it loads the next character into the data register. On the following clock edge it inverts the strobe. After the twelfth character it freezes the link and raises a done flag, which stays set until reset. The acknowledge input is taken to be synchronous to the clock already.

Top module: `tgl_msg_tx`

## Requirements
- R1: While rst_ni is low, strobe_o is 0, data_o is 0x00 and done_o is 0. After reset is released, sending restarts from character index 0.
- R2: Before done, while ack_i equals strobe_o in the waiting state, neither data_o nor strobe_o changes on any clock edge.
- R3: On the first clock edge at which the waiting transmitter sees ack_i different from strobe_o, data_o takes the next character and strobe_o keeps its level.
- R4: strobe_o inverts on exactly the clock edge after the edge that loaded data_o. It changes at no other time.
- R5: The characters are sent in this order: 0x48 0x65 0x6C 0x6C 0x6F 0x20 0x57 0x6F 0x72 0x6C 0x64 0x0A ("Hello World" then a line feed).
- R6: done_o rises on the edge that inverts the strobe for the twelfth character and stays 1 until reset. While done_o is 1, data_o and strobe_o hold their values whatever ack_i does.
- R7: data_o does not change on the strobe-inverting edge. It holds its value through every cycle until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | Acknowledge level from the receiver (synchronous) |
| data_o | output | 8 | Current character |
| strobe_o | output | 1 | Transfer level; each inversion announces a byte |
| done_o | output | 1 | Sticky flag: the whole message has been sent |

## Verification
A transfer starts with the acknowledge change that the bench drives at a falling edge. The new character is due on data_o one rising edge later, and the strobe inversion one further rising edge after that. The bench therefore samples data_o at the next falling edge and the strobe and done flag at the falling edge after it. A per-byte receiver delay then holds acknowledge equal to strobe for a set number of cycles, and both outputs are checked as stable at every falling edge of that wait. The reset cases also use falling-edge samples, including a reset applied in the gap between the data load and the strobe inversion.

// File: rtl/tgl_tx_pkg.sv
package tgl_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int MSG_LEN = 12;
  localparam int IDX_W   = $clog2(MSG_LEN);

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_DONE  = 2'd2
  } tx_state_e;

  // message text, index 0 first
  function automatic logic [DATA_W-1:0] msg_char(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] c;
    case (idx)
      4'd0:    c = 8'h48;
      4'd1:    c = 8'h65;
      4'd2:    c = 8'h6C;
      4'd3:    c = 8'h6C;
      4'd4:    c = 8'h6F;
      4'd5:    c = 8'h20;
      4'd6:    c = 8'h57;
      4'd7:    c = 8'h6F;
      4'd8:    c = 8'h72;
      4'd9:    c = 8'h6C;
      4'd10:   c = 8'h64;
      4'd11:   c = 8'h0A;
      default: c = 8'h00;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tgl_msg_rom.sv
module tgl_msg_rom
  import tgl_tx_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] char_o
);
  always_comb char_o = msg_char(idx_i);
endmodule

// File: rtl/tgl_tx_fsm.sv
module tgl_tx_fsm
  import tgl_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             drive_o,
  output logic             strobe_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_LEN - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             strobe_q;
  logic             done_q;

  // proceed only once the receiver level differs from ours
  assign load_o  = (state_q == ST_WAIT) && (ack_i != strobe_q);
  assign drive_o = (state_q == ST_DRIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT;
      idx_q    <= '0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_WAIT: if (load_o) state_q <= ST_DRIVE;
        ST_DRIVE: begin
          strobe_q <= ~strobe_q;
          if (idx_q == LAST_IDX) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign idx_o    = idx_q;
  assign strobe_o = strobe_q;
  assign done_o   = done_q;
endmodule

// File: rtl/tgl_msg_tx.sv
module tgl_msg_tx
  import tgl_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              strobe_o,
  output logic              done_o
);
  logic [IDX_W-1:0]  idx_w;
  logic [DATA_W-1:0] char_w;
  logic              load_w;
  logic              drive_w;
  logic [DATA_W-1:0] data_q;

  tgl_tx_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (ack_i),
    .idx_o    (idx_w),
    .load_o   (load_w),
    .drive_o  (drive_w),
    .strobe_o (strobe_o),
    .done_o   (done_o)
  );

  tgl_msg_rom u_rom (
    .idx_i  (idx_w),
    .char_o (char_w)
  );

  // data held between transfers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (load_w) data_q <= char_w;
  end

  assign data_o = data_q;
endmodule

// File: rtl/tgl_msg_tx_chk.sv
module tgl_msg_tx_chk
  import tgl_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic [DATA_W-1:0] data_o,
  input logic              strobe_o,
  input logic              done_o,
  input logic              drive_i
);
  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_i && !done_o && ack_i == strobe_o) |=> (!drive_i && $stable(data_o) && $stable(strobe_o)));

  // R3
  go_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_i && !done_o && ack_i != strobe_o) |=> (drive_i && $stable(strobe_o)));

  // R4
  strobe_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |=> (strobe_o != $past(strobe_o)));

  // R4
  strobe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_i |=> $stable(strobe_o));

  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(data_o) && $stable(strobe_o)));

  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |=> $stable(data_o));
endmodule

bind tgl_msg_tx tgl_msg_tx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .data_o   (data_o),
  .strobe_o (strobe_o),
  .done_o   (done_o),
  .drive_i  (drive_w)
);

// File: tb/sim_tgl_msg_tx.sv
module sim_tgl_msg_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ack = 1'b0;
  logic [7:0] data;
  logic       strobe;
  logic       done;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tgl_msg_tx u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .ack_i    (ack),
    .data_o   (data),
    .strobe_o (strobe),
    .done_o   (done)
  );

  // {receiver delay, expected character}
  localparam logic [11:0] VEC [0:11] = '{
    {4'd0, 8'h48}, {4'd1, 8'h65}, {4'd3, 8'h6C}, {4'd0, 8'h6C},
    {4'd2, 8'h6F}, {4'd5, 8'h20}, {4'd0, 8'h57}, {4'd1, 8'h6F},
    {4'd0, 8'h72}, {4'd4, 8'h6C}, {4'd2, 8'h64}, {4'd1, 8'h0A}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // receiver toggles ack, then holds it for dly cycles
  task automatic send_byte(input logic [7:0] exp, input int dly, input logic last);
    logic prev;
    prev = strobe;
    ack  = ~ack;
    @(negedge clk);
    check("R3/R5 data loaded", {24'd0, data}, {24'd0, exp});
    check("R3 strobe held on load", {31'd0, strobe}, {31'd0, prev});
    @(negedge clk);
    check("R4 strobe inverted", {31'd0, strobe}, {31'd0, ~prev});
    check("R7 data held on toggle", {24'd0, data}, {24'd0, exp});
    check("R6 done level", {31'd0, done}, {31'd0, last});
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check("R2 stall strobe", {31'd0, strobe}, {31'd0, ~prev});
      check("R2 stall data", {24'd0, data}, {24'd0, exp});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobe", {31'd0, strobe}, 32'd0);
    check("R1 reset data", {24'd0, data}, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    rst_ni = 1'b1;

    // ack equals strobe: must stall
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 initial stall strobe", {31'd0, strobe}, 32'd0);
      check("R2 initial stall data", {24'd0, data}, 32'd0);
    end

    for (int i = 0; i < 12; i++)
      send_byte(VEC[i][7:0], int'(VEC[i][11:8]), i == 11);

    // after done, ack activity is ignored
    for (int k = 0; k < 4; k++) begin
      ack = ~ack;
      @(negedge clk);
      check("R6 done sticky", {31'd0, done}, 32'd1);
      check("R6 data frozen", {24'd0, data}, 32'h0A);
      check("R6 strobe frozen", {31'd0, strobe}, 32'd0);
    end

    // reset after completion, restart from index 0
    rst_ni = 1'b0;
    ack = 1'b0;
    @(negedge clk);
    check("R1 reset clears done", {31'd0, done}, 32'd0);
    check("R1 reset clears data", {24'd0, data}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    send_byte(8'h48, 0, 1'b0);
    send_byte(8'h65, 1, 1'b0);

    // reset between data load and strobe toggle
    ack = ~ack;
    @(negedge clk);
    check("R5 third char", {24'd0, data}, 32'h6C);
    #1 rst_ni = 1'b0;
    @(negedge clk);
    check("R1 mid-transfer strobe", {31'd0, strobe}, 32'd0);
    check("R1 mid-transfer data", {24'd0, data}, 32'd0);
    ack = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 post-reset stall", {31'd0, strobe}, 32'd0);
    send_byte(8'h48, 2, 1'b0);
    send_byte(8'h65, 0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule